// File: doc/BRIEF.md
# Multi-Master Byte Transmitter with Arbitration Fallback

This block sends one byte at a time onto a two-wire open-drain serial bus as a clock-generating master. It watches the bus at every clock rise to see whether another master is overriding it. Both bus lines are modelled as pull-low enables, with 1 meaning the line is pulled low. The block samples the resolved bus levels and compares the data level it intends with the level actually on the data line. When the two disagree, the block has lost arbitration. It stops driving both lines and becomes a receiver for the rest of the byte. It then counts the winning master's clock pulses to completion.

At the end of every byte the block captures the eight data bits seen on the bus. It stretches the clock line low and raises a one-cycle interrupt. It keeps an active-low pending flag at 0 until software touches the data buffer or writes the control word. Software starts a byte by writing the data buffer while the block is in master-transmitter mode. Any data-buffer read or write, or any control write, clears the arbitration-lost flag and releases the clock stretch.

Top module: `mm_arb_xmit`

## Requirements
- R1: A data-buffer write while master=1, xmit=1 and no byte in progress starts a byte. SCL is generated with HALF system cycles per phase, low phase first. Data bits go out MSB first, and SDA changes only on SCL falls.
- R2: On each rising edge of bus SCL during the eight data bits, while master=1 and xmit=1, the driven SDA level is compared with bus SDA. A mismatch sets arb_lost=1. For two competing bytes, the block loses exactly when the other byte is numerically smaller.
- R3: The cycle after a mismatch, mode_master=0 and mode_xmit=0.
- R4: After arbitration is lost, scl_pull=0 and sda_pull=0 until the byte ends.
- R5: After a loss, the block keeps counting bus SCL rises. The byte ends at the bus SCL fall that follows the ninth rise.
- R6: At the end of a byte, all of the following hold:
  - pin_n becomes 0 and irq pulses for exactly one cycle.
  - scl_pull becomes 1 (the clock is held low).
  - db_rdata holds the eight bits sampled from bus SDA on rises one to eight, with the first one as the MSB.
- R7: A db_wr, a db_rd or a ctrl_wr sets arb_lost=0 and pin_n=1 and releases the clock hold. A mismatch in the same cycle takes priority.
- R8: Bus SDA on the ninth (acknowledge) clock is never compared. A low acknowledge does not set arb_lost.
- R9: When both masters send identical bytes, nobody loses. A following byte started directly from the held state is arbitrated bit by bit again.
- R10: ctrl_wr loads mode_master from ctrl_wdata[1] and mode_xmit from ctrl_wdata[0], but only when no byte is in progress. During a byte the mode bits keep their values.
- R11: After reset, all of the following hold:
  - scl_pull=0, sda_pull=0, mode_master=0, mode_xmit=0, arb_lost=0, pin_n=1, irq=0 and db_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Resolved bus clock level |
| sda_in | input | 1 | Resolved bus data level |
| scl_pull | output | 1 | Pull bus clock low when 1 |
| sda_pull | output | 1 | Pull bus data low when 1 |
| db_wr | input | 1 | Data-buffer write strobe |
| db_rd | input | 1 | Data-buffer read strobe |
| db_wdata | input | DATA_W | Data-buffer write value |
| db_rdata | output | DATA_W | Data-buffer contents |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 2 | Bit 1 master, bit 0 transmit |
| mode_master | output | 1 | Master mode bit |
| mode_xmit | output | 1 | Transmit mode bit |
| arb_lost | output | 1 | Arbitration-lost flag |
| pin_n | output | 1 | Pending flag, 0 after a byte ends |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with DATA_W=8 and HALF=2. A byte then lasts about forty cycles, so every transmitted value can be matched against nine competitor values in one run. The nine competitors are the same byte and the byte with each single bit flipped. This reaches a loss at every bit position, wins at every position and full ties, with second-byte arbitration after each tie. A bench peer master runs its clock in lockstep and drives an acknowledge. The expected bus byte and loss flag follow from the numeric minimum of the two bytes.

// File: rtl/mmarb_pkg.sv
package mmarb_pkg;
  localparam int CTRL_MASTER_BIT = 1;
  localparam int CTRL_XMIT_BIT   = 0;

  typedef struct packed {
    logic master;
    logic xmit;
  } mode_t;

  function automatic mode_t decode_ctrl(input logic [1:0] w);
    mode_t m;
    m.master = w[CTRL_MASTER_BIT];
    m.xmit   = w[CTRL_XMIT_BIT];
    return m;
  endfunction
endpackage

// File: rtl/mmarb_edge.sv
module mmarb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/mmarb_sclgen.sv
module mmarb_sclgen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic low_ph
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [HW-1:0] hc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      hc     <= '0;
      low_ph <= 1'b1;
    end else if (hc == HW'(HALF - 1)) begin
      hc     <= '0;
      low_ph <= ~low_ph;
    end else begin
      hc <= hc + 1'b1;
    end
  end
endmodule

// File: rtl/mmarb_bitseq.sv
module mmarb_bitseq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_msb,
  input  logic              busy,
  input  logic              rise,
  input  logic              fall,
  input  logic              sda_in,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_bit,
  output logic              drv_en,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CW = $clog2(DATA_W + 2);
  logic [CW-1:0] cnt;

  function automatic logic pick(input logic [DATA_W-1:0] v, input logic [CW-1:0] i);
    logic r;
    r = 1'b1;
    for (int j = 0; j < DATA_W; j++)
      if (int'(i) == DATA_W - 1 - j) r = v[j];
    return r;
  endfunction

  assign byte_done = busy & fall & (cnt == CW'(DATA_W + 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      tx_bit  <= 1'b1;
      drv_en  <= 1'b0;
      rx_byte <= '0;
    end else if (start) begin
      cnt    <= '0;
      tx_bit <= start_msb;
      drv_en <= 1'b1;
    end else if (busy) begin
      if (rise) begin
        cnt <= cnt + 1'b1;
        if (cnt < CW'(DATA_W)) rx_byte <= {rx_byte[DATA_W-2:0], sda_in};
      end
      if (fall) begin
        if (cnt == CW'(DATA_W))    drv_en <= 1'b0;
        else if (cnt < CW'(DATA_W)) tx_bit <= pick(tx_byte, cnt);
      end
    end
  end
endmodule

// File: rtl/mm_arb_xmit.sv
module mm_arb_xmit
  import mmarb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              db_wr,
  input  logic              db_rd,
  input  logic [DATA_W-1:0] db_wdata,
  output logic [DATA_W-1:0] db_rdata,
  input  logic              ctrl_wr,
  input  logic [1:0]        ctrl_wdata,
  output logic              mode_master,
  output logic              mode_xmit,
  output logic              arb_lost,
  output logic              pin_n,
  output logic              irq
);
  mode_t             mode_q;
  logic              busy, hold, lost_q, pin_q, irq_q;
  logic [DATA_W-1:0] txb, db_q, rx_byte;
  logic              scl_rise, scl_fall, low_ph, tx_bit, drv_en;
  logic              start, run_gen, arb_mismatch, byte_done, access_clr;

  assign start        = db_wr & ~busy & mode_q.master & mode_q.xmit;
  assign run_gen      = busy & mode_q.master;
  assign access_clr   = db_wr | db_rd | ctrl_wr;
  assign arb_mismatch = busy & mode_q.master & mode_q.xmit & drv_en
                        & scl_rise & (sda_in != tx_bit);

  mmarb_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(scl_in), .rise(scl_rise), .fall(scl_fall)
  );

  mmarb_sclgen #(.HALF(HALF)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(run_gen), .low_ph(low_ph)
  );

  mmarb_bitseq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_msb(db_wdata[DATA_W-1]),
    .busy(busy), .rise(scl_rise), .fall(scl_fall), .sda_in(sda_in),
    .tx_byte(txb), .tx_bit(tx_bit), .drv_en(drv_en), .byte_done(byte_done),
    .rx_byte(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      busy   <= 1'b0;
      hold   <= 1'b0;
      lost_q <= 1'b0;
      pin_q  <= 1'b1;
      irq_q  <= 1'b0;
      txb    <= '0;
      db_q   <= '0;
    end else begin
      irq_q <= byte_done;
      if (start)          busy <= 1'b1;
      else if (byte_done) busy <= 1'b0;

      if (arb_mismatch)         mode_q <= '0;
      else if (ctrl_wr && !busy) mode_q <= decode_ctrl(ctrl_wdata);

      if (arb_mismatch)    lost_q <= 1'b1;
      else if (access_clr) lost_q <= 1'b0;

      if (byte_done)       pin_q <= 1'b0;
      else if (access_clr) pin_q <= 1'b1;

      if (byte_done)       hold <= 1'b1;
      else if (access_clr) hold <= 1'b0;

      if (start) txb <= db_wdata;

      if (byte_done)  db_q <= rx_byte;
      else if (db_wr) db_q <= db_wdata;
    end
  end

  assign scl_pull    = (run_gen & low_ph) | hold;
  assign sda_pull    = busy & mode_q.master & mode_q.xmit & drv_en & ~tx_bit;
  assign db_rdata    = db_q;
  assign mode_master = mode_q.master;
  assign mode_xmit   = mode_q.xmit;
  assign arb_lost    = lost_q;
  assign pin_n       = pin_q;
  assign irq         = irq_q;
endmodule

// File: rtl/mmarb_chk.sv
module mmarb_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_pull,
  input logic sda_pull,
  input logic pin_n,
  input logic irq,
  input logic arb_lost,
  input logic mode_master,
  input logic mode_xmit,
  input logic db_wr,
  input logic db_rd,
  input logic ctrl_wr,
  input logic arb_mismatch,
  input logic byte_done,
  input logic busy
);
  a_r3_mode_drop: assert property (@(posedge clk) disable iff (!rst_n)
    arb_mismatch |=> (!mode_master && !mode_xmit && arb_lost));

  a_r2_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> $past(arb_mismatch));

  a_r4_sda_free: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_master |-> !sda_pull);

  a_r4_scl_free: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_master) |-> !scl_pull);

  a_r6_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (irq && !pin_n && scl_pull && !busy));

  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((db_wr || db_rd || ctrl_wr) && !arb_mismatch && !byte_done) |=> (!arb_lost && pin_n));
endmodule

bind mm_arb_xmit mmarb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .pin_n(pin_n), .irq(irq), .arb_lost(arb_lost), .mode_master(mode_master),
  .mode_xmit(mode_xmit), .db_wr(db_wr), .db_rd(db_rd), .ctrl_wr(ctrl_wr),
  .arb_mismatch(arb_mismatch), .byte_done(byte_done), .busy(busy)
);

// File: tb/tb_mm_arb_xmit.sv
module tb_mm_arb_xmit;
  localparam int HALF = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       scl_pull, sda_pull, db_wr, db_rd, ctrl_wr;
  logic [7:0] db_wdata, db_rdata;
  logic [1:0] ctrl_wdata;
  logic       mode_master, mode_xmit, arb_lost, pin_n, irq;
  logic       scl_bus, sda_bus;

  // peer master model
  logic       b_act, b_low, b_drv, b_bit, b_ack, b_q, b_go;
  int         b_hc, b_cnt;
  logic [7:0] b_byte, b_load;

  assign scl_bus = !(scl_pull | (b_act & b_low));
  assign sda_bus = !(sda_pull | (b_act & b_drv & !b_bit));

  mm_arb_xmit #(.DATA_W(8), .HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .db_wr(db_wr), .db_rd(db_rd),
    .db_wdata(db_wdata), .db_rdata(db_rdata), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .mode_master(mode_master), .mode_xmit(mode_xmit),
    .arb_lost(arb_lost), .pin_n(pin_n), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      b_act <= 1'b0; b_low <= 1'b1; b_drv <= 1'b0; b_bit <= 1'b1;
      b_q <= 1'b1; b_hc <= 0; b_cnt <= 0; b_byte <= 8'h00;
    end else begin
      b_q <= scl_bus;
      if (b_go) begin
        b_act <= 1'b1; b_low <= 1'b1; b_hc <= 0; b_cnt <= 0;
        b_bit <= b_load[7]; b_drv <= 1'b1; b_byte <= b_load;
      end else if (b_act) begin
        if (b_hc == HALF - 1) begin b_hc <= 0; b_low <= !b_low; end
        else b_hc <= b_hc + 1;
        if (scl_bus && !b_q) begin
          if (b_drv && (sda_bus != b_bit)) b_act <= 1'b0;
          b_cnt <= b_cnt + 1;
        end
        if (!scl_bus && b_q) begin
          if (b_cnt == 9) b_act <= 1'b0;
          else if (b_cnt == 8) begin b_drv <= b_ack; b_bit <= 1'b0; end
          else b_bit <= b_byte[7 - b_cnt];
        end
      end
    end
  end

  int nchk = 0, nerr = 0, viol = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic do_ctrl(input logic [1:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic do_start(input logic [7:0] a, input logic [7:0] b, input bit use_b, input bit ack);
    db_wr = 1'b1; db_wdata = a;
    b_go = use_b; b_load = b; b_ack = ack;
    @(negedge clk);
    db_wr = 1'b0; b_go = 1'b0;
  endtask

  // waits for irq; tallies any line driven after a loss (R4)
  task automatic wait_irq(input bool_mid, output bit ok);
    ok = 0;
    for (int t = 0; t < 400; t++) begin
      if (irq) begin ok = 1; break; end
      if (arb_lost && !mode_master && pin_n && (scl_pull || sda_pull)) viol++;
      if (bool_mid && t == 5) do_ctrl(2'b00);
      else @(negedge clk);
    end
  endtask

  task automatic run_byte(input logic [7:0] a, input logic [7:0] b, input bit use_b,
                          input bit ack, input bit mid_ctrl);
    logic [7:0] eb;
    bit lose, ok;
    eb   = use_b ? b : 8'hFF;
    lose = (eb < a);
    viol = 0;
    do_start(a, b, use_b, ack);
    wait_irq(mid_ctrl, ok);
    check("R5 byte completes", ok, 1);
    check("R2 arb_lost vs numeric rule", arb_lost, lose);
    check("R3 master after byte (R10 mid-byte write)", mode_master, !lose);
    check("R3 xmit after byte", mode_xmit, !lose);
    check("R6 pin_n low", pin_n, 0);
    check("R6 captured bus byte", db_rdata, (eb < a) ? eb : a);
    check("R6 clock held low", scl_pull, 1);
    check("R4 lines released after loss", viol, 0);
    @(negedge clk);
    check("R6 irq single pulse", irq, 0);
  endtask

  task automatic clear_by(input int how);
    if (how == 1) begin
      db_wr = 1'b1; db_wdata = 8'h5A; @(negedge clk); db_wr = 1'b0;
      check("R7 db_wr loads buffer", db_rdata, 8'h5A);
    end else if (how == 2) begin
      do_ctrl(2'b11);
    end else begin
      db_rd = 1'b1; @(negedge clk); db_rd = 1'b0;
    end
    check("R7 arb_lost cleared", arb_lost, 0);
    check("R7 pin_n set", pin_n, 1);
    check("R7 hold released", scl_pull, 0);
    do_ctrl(2'b11);
    check("R10 mode set by ctrl", {mode_master, mode_xmit}, 2'b11);
  endtask

  initial begin
    db_wr = 0; db_rd = 0; ctrl_wr = 0; db_wdata = 0; ctrl_wdata = 0;
    b_go = 0; b_load = 0; b_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset scl_pull", scl_pull, 0);
    check("R11 reset sda_pull", sda_pull, 0);
    check("R11 reset modes", {mode_master, mode_xmit}, 2'b00);
    check("R11 reset arb_lost", arb_lost, 0);
    check("R11 reset pin_n", pin_n, 1);
    check("R11 reset irq", irq, 0);
    check("R11 reset buffer", db_rdata, 0);
    // not master: a buffer write must not start a byte (R1)
    db_wr = 1'b1; db_wdata = 8'h00; @(negedge clk); db_wr = 1'b0;
    repeat (8) @(negedge clk);
    check("R1 no start when not master", {scl_pull, sda_pull, irq}, 3'b000);
    do_ctrl(2'b11);
    check("R10 mode set", {mode_master, mode_xmit}, 2'b11);
    // alone on the bus (R1)
    for (int i = 0; i < 4; i++) begin
      run_byte(8'(i * 77 + 3), 8'hFF, 0, 0, 0);
      clear_by(0);
    end
    // sweep: every byte against itself and its single-bit flips
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 9; k++) begin
        logic [7:0] av, bv;
        bit tie;
        av  = 8'(a);
        tie = (k == 8);
        bv  = tie ? av : (av ^ (8'h01 << k));
        // R8: peer acks on the ninth clock whenever a[0]
        run_byte(av, bv, 1, av[0], tie && av[1]);
        if (tie) begin
          // R9: second byte started directly from the held state
          run_byte(av, av ^ 8'h80, 1, 1'b0, 0);
        end
        clear_by(arb_lost ? ((a + k) % 3) : 0);
      end
    end
    finish_run();
  end
endmodule